// File: doc/BRIEF.md
# Segmented-Routing Switch Box

This block sits at the corner of one logic tile and joins the horizontal and vertical routing tracks that meet there. Each of the `NTRK` tracks has one end on each of the four sides: north and south for the vertical run, east and west for the horizontal run. Real pass-transistor wiring is bidirectional. Here each track end is split into a directed input and a directed output, and each direction carries a drive-valid flag that says whether anything is driving it.

The lowest `NSW` tracks are switchable. Six configuration bits per track close links between pairs of sides. Closed links form transitive nets, and every side of a net sees the value driven by the other members of that net. The remaining tracks are longer segments. They need no configuration and simply continue straight across the corner: west to east for the horizontal run, north to south for the vertical run.

Configuration is written through a parallel load port. Two members of one net driving opposite values raise a per-track conflict flag.

Top module: `swbox_top`

## Requirements
- R1: After a synchronous active-low reset, every configuration bit is zero. With all links open, no output of a switchable track is flagged valid, whatever the inputs.
- R2: When `cfg_load` is high at a rising clock edge, `cfg_data` is captured and governs routing from that edge on. While `cfg_load` is low, the stored configuration keeps its value and changes on `cfg_data` have no effect. Track k owns bits [6k+5:6k]. The link order inside a group, from bit 0 up, is: N-S, E-W, N-E, N-W, S-E, S-W.
- R3: On every track at or above `NSW`, each output combinationally copies the input on the opposite side, value and valid flag: north/south and east/west. Configuration has no effect on these tracks.
- R4: On a switchable track, a single closed link between two sides copies each side's input value and valid flag to the other side's output in the same cycle.
- R5: Closed links are transitive. A value driven on one side reaches every side joined to it through any chain of closed links on the same track.
- R6: A side's output is valid only when some other member of its net drives. A side never sees its own drive echoed back.
- R7: A switchable track's `conflict` bit is high exactly when its nets contain members driving 1 and 0 at once. Agreeing drivers raise no conflict. An output whose net has several other drivers shows the OR of their values.
- R8: The configuration group of one switchable track has no effect on any other track.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture `cfg_data` at the next rising edge |
| cfg_data | input | 6*NSW | Link enables, six per switchable track |
| n_in | input | NTRK | Value driven into the north ends |
| n_in_vld | input | NTRK | North ends are driven |
| s_in | input | NTRK | Value driven into the south ends |
| s_in_vld | input | NTRK | South ends are driven |
| e_in | input | NTRK | Value driven into the east ends |
| e_in_vld | input | NTRK | East ends are driven |
| w_in | input | NTRK | Value driven into the west ends |
| w_in_vld | input | NTRK | West ends are driven |
| n_out | output | NTRK | Value delivered at the north ends |
| n_out_vld | output | NTRK | North output is driven by another side |
| s_out | output | NTRK | Value delivered at the south ends |
| s_out_vld | output | NTRK | South output is driven by another side |
| e_out | output | NTRK | Value delivered at the east ends |
| e_out_vld | output | NTRK | East output is driven by another side |
| w_out | output | NTRK | Value delivered at the west ends |
| w_out_vld | output | NTRK | West output is driven by another side |
| conflict | output | NSW | Opposite values driven within one net of the track |

## Verification
The bench builds the block with its default four tracks, two of them switchable. That gives a 12-bit configuration word, small enough that all 64 link settings of a switchable track can be swept exhaustively while the other switchable track takes the complementary setting. Each setting is exercised with several drive patterns, so every shape of transitive net is covered, including two separate pairs and a three-way merge. Because the two default pass-through tracks stay in the instance, the bench can also show that a full configuration leaves them unchanged.

// File: rtl/swbox_pkg.sv
`timescale 1ns/1ps
// Package: shared constants of the switch box.
// Assumes sides are indexed N=0, S=1, E=2, W=3 inside every per-track vector.
package swbox_pkg;
    localparam int NSIDES        = 4;
    localparam int LINKS_PER_TRK = 6;
    localparam int SIDE_N        = 0;
    localparam int SIDE_S        = 1;
    localparam int SIDE_E        = 2;
    localparam int SIDE_W        = 3;
    // Endpoints of each link bit: N-S, E-W, N-E, N-W, S-E, S-W.
    localparam int LINK_A [LINKS_PER_TRK] = '{SIDE_N, SIDE_E, SIDE_N, SIDE_N, SIDE_S, SIDE_S};
    localparam int LINK_B [LINKS_PER_TRK] = '{SIDE_S, SIDE_W, SIDE_E, SIDE_W, SIDE_E, SIDE_W};
endpackage

// File: rtl/swbox_cfg.sv
`timescale 1ns/1ps
// Module: configuration register of the switch box.
// Holds the link enables. Loaded in parallel when load is high; cleared by
// synchronous active-low reset. Assumes load is synchronous to clk.
module swbox_cfg #(
    parameter int CFG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] din,
    output logic [CFG_W-1:0] q
);
    // Capture a new configuration word, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/swbox_net.sv
`timescale 1ns/1ps
// Module: connection matrix of one switchable track.
// Closes the six side-pair links and forms transitive nets by closure over
// the four sides. Each side receives the OR of the values driven by the other
// members of its net. Purely combinational; assumes link is stable per cycle.
module swbox_net
    import swbox_pkg::*;
(
    input  logic [LINKS_PER_TRK-1:0] link,
    input  logic [NSIDES-1:0]        din,
    input  logic [NSIDES-1:0]        dvld,
    output logic [NSIDES-1:0]        dout,
    output logic [NSIDES-1:0]        dovld,
    output logic                     conflict
);
    logic [NSIDES-1:0] reach [NSIDES];
    logic [NSIDES-1:0] others;
    logic              any_hi;
    logic              any_lo;

    // Build reachability: direct links first, then transitive closure.
    always_comb begin
        for (int i = 0; i < NSIDES; i++) begin
            reach[i] = NSIDES'(1) << i;
        end
        for (int l = 0; l < LINKS_PER_TRK; l++) begin
            if (link[l]) begin
                reach[LINK_A[l]][LINK_B[l]] = 1'b1;
                reach[LINK_B[l]][LINK_A[l]] = 1'b1;
            end
        end
        for (int k = 0; k < NSIDES; k++) begin
            for (int i = 0; i < NSIDES; i++) begin
                if (reach[i][k]) begin
                    reach[i] = reach[i] | reach[k];
                end
            end
        end
    end

    // Per side: merge drives of the other net members and flag clashes.
    always_comb begin
        conflict = 1'b0;
        others   = '0;
        any_hi   = 1'b0;
        any_lo   = 1'b0;
        for (int s = 0; s < NSIDES; s++) begin
            others   = reach[s] & ~(NSIDES'(1) << s);
            dovld[s] = |(others & dvld);
            dout[s]  = |(others & dvld & din);
            any_hi   = |(reach[s] & dvld & din);
            any_lo   = |(reach[s] & dvld & ~din);
            conflict = conflict | (any_hi & any_lo);
        end
    end
endmodule

// File: rtl/swbox_thru.sv
`timescale 1ns/1ps
// Module: fixed pass-through of one long track.
// The vertical run joins north and south; the horizontal run joins east and
// west. Needs no configuration; assumes each run has at most one driver.
module swbox_thru
    import swbox_pkg::*;
(
    input  logic [NSIDES-1:0] din,
    input  logic [NSIDES-1:0] dvld,
    output logic [NSIDES-1:0] dout,
    output logic [NSIDES-1:0] dovld
);
    // Cross each side to the opposite side of the same run.
    always_comb begin
        dout[SIDE_N]  = din[SIDE_S];
        dout[SIDE_S]  = din[SIDE_N];
        dout[SIDE_E]  = din[SIDE_W];
        dout[SIDE_W]  = din[SIDE_E];
        dovld[SIDE_N] = dvld[SIDE_S];
        dovld[SIDE_S] = dvld[SIDE_N];
        dovld[SIDE_E] = dvld[SIDE_W];
        dovld[SIDE_W] = dvld[SIDE_E];
    end
endmodule

// File: rtl/swbox_top.sv
`timescale 1ns/1ps
// Module: segmented-routing switch box at one tile corner.
// Tracks below NSW are switchable through six link bits each; the rest pass
// straight through. Assumes 0 < NSW <= NTRK.
module swbox_top
    import swbox_pkg::*;
#(
    parameter int NTRK = 4,
    parameter int NSW  = 2,
    localparam int CFG_W = NSW * LINKS_PER_TRK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [NTRK-1:0]  n_in,
    input  logic [NTRK-1:0]  n_in_vld,
    input  logic [NTRK-1:0]  s_in,
    input  logic [NTRK-1:0]  s_in_vld,
    input  logic [NTRK-1:0]  e_in,
    input  logic [NTRK-1:0]  e_in_vld,
    input  logic [NTRK-1:0]  w_in,
    input  logic [NTRK-1:0]  w_in_vld,
    output logic [NTRK-1:0]  n_out,
    output logic [NTRK-1:0]  n_out_vld,
    output logic [NTRK-1:0]  s_out,
    output logic [NTRK-1:0]  s_out_vld,
    output logic [NTRK-1:0]  e_out,
    output logic [NTRK-1:0]  e_out_vld,
    output logic [NTRK-1:0]  w_out,
    output logic [NTRK-1:0]  w_out_vld,
    output logic [NSW-1:0]   conflict
);
    logic [CFG_W-1:0] cfg_q;

    swbox_cfg #(.CFG_W(CFG_W)) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cfg_load),
        .din  (cfg_data),
        .q    (cfg_q)
    );

    for (genvar t = 0; t < NTRK; t++) begin : g_trk
        logic [NSIDES-1:0] tin_d;
        logic [NSIDES-1:0] tin_v;
        logic [NSIDES-1:0] tout_d;
        logic [NSIDES-1:0] tout_v;

        // Gather this track's four ends, indexed by side.
        assign tin_d = {w_in[t], e_in[t], s_in[t], n_in[t]};
        assign tin_v = {w_in_vld[t], e_in_vld[t], s_in_vld[t], n_in_vld[t]};

        if (t < NSW) begin : g_sw
            swbox_net u_net (
                .link    (cfg_q[t*LINKS_PER_TRK +: LINKS_PER_TRK]),
                .din     (tin_d),
                .dvld    (tin_v),
                .dout    (tout_d),
                .dovld   (tout_v),
                .conflict(conflict[t])
            );
        end else begin : g_pt
            swbox_thru u_thru (
                .din  (tin_d),
                .dvld (tin_v),
                .dout (tout_d),
                .dovld(tout_v)
            );
        end

        // Scatter results back to the per-side ports.
        assign n_out[t]     = tout_d[SIDE_N];
        assign s_out[t]     = tout_d[SIDE_S];
        assign e_out[t]     = tout_d[SIDE_E];
        assign w_out[t]     = tout_d[SIDE_W];
        assign n_out_vld[t] = tout_v[SIDE_N];
        assign s_out_vld[t] = tout_v[SIDE_S];
        assign e_out_vld[t] = tout_v[SIDE_E];
        assign w_out_vld[t] = tout_v[SIDE_W];
    end
endmodule

// File: rtl/swbox_chk.sv
`timescale 1ns/1ps
// Module: property checker for swbox_top, attached by bind below.
// Observes ports and the stored configuration only.
module swbox_chk #(
    parameter int NTRK = 4,
    parameter int NSW  = 2,
    localparam int CFG_W = NSW * 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic [CFG_W-1:0] cfg_data,
    input logic [CFG_W-1:0] cfg_q,
    input logic [NTRK-1:0]  n_in,
    input logic [NTRK-1:0]  n_in_vld,
    input logic [NTRK-1:0]  s_in,
    input logic [NTRK-1:0]  s_in_vld,
    input logic [NTRK-1:0]  e_in,
    input logic [NTRK-1:0]  e_in_vld,
    input logic [NTRK-1:0]  w_in,
    input logic [NTRK-1:0]  w_in_vld,
    input logic [NTRK-1:0]  n_out,
    input logic [NTRK-1:0]  n_out_vld,
    input logic [NTRK-1:0]  s_out,
    input logic [NTRK-1:0]  s_out_vld,
    input logic [NTRK-1:0]  e_out,
    input logic [NTRK-1:0]  e_out_vld,
    input logic [NTRK-1:0]  w_out,
    input logic [NTRK-1:0]  w_out_vld,
    input logic [NSW-1:0]   conflict
);
    AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (cfg_q == $past(cfg_data))); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(cfg_q)); // R2

    for (genvar k = 0; k < NTRK; k++) begin : g_chk
        if (k < NSW) begin : g_sw
            AST_OPEN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[k*6 +: 6] == 6'd0) |-> !(n_out_vld[k] | s_out_vld[k] | e_out_vld[k] | w_out_vld[k])); // R1
            AST_NS_LINK_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[k*6] && s_in_vld[k]) |-> n_out_vld[k]); // R4
            AST_NO_SELF_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
                n_out_vld[k] |-> (s_in_vld[k] | e_in_vld[k] | w_in_vld[k])); // R6
            AST_CONFLICT_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
                conflict[k] |-> ($countones({n_in_vld[k], s_in_vld[k], e_in_vld[k], w_in_vld[k]}) >= 2)); // R7
        end else begin : g_pt
            AST_THRU_VERT: assert property (@(posedge clk) disable iff (!rst_n)
                (n_out[k] == s_in[k]) && (n_out_vld[k] == s_in_vld[k]) && (s_out[k] == n_in[k])); // R3
            AST_THRU_HORZ: assert property (@(posedge clk) disable iff (!rst_n)
                (e_out[k] == w_in[k]) && (e_out_vld[k] == w_in_vld[k]) && (w_out[k] == e_in[k])); // R3
        end
    end
endmodule

bind swbox_top swbox_chk #(.NTRK(NTRK), .NSW(NSW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_data(cfg_data), .cfg_q(cfg_q),
    .n_in(n_in), .n_in_vld(n_in_vld), .s_in(s_in), .s_in_vld(s_in_vld),
    .e_in(e_in), .e_in_vld(e_in_vld), .w_in(w_in), .w_in_vld(w_in_vld),
    .n_out(n_out), .n_out_vld(n_out_vld), .s_out(s_out), .s_out_vld(s_out_vld),
    .e_out(e_out), .e_out_vld(e_out_vld), .w_out(w_out), .w_out_vld(w_out_vld),
    .conflict(conflict)
);

// File: tb/test_swbox_top.sv
`timescale 1ns/1ps
module test_swbox_top;
    localparam int NT = 4;
    localparam int NS = 2;
    localparam int CW = NS * 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [CW-1:0] cfg_data = '0;
    logic [3:0][NT-1:0] in_d = '0;
    logic [3:0][NT-1:0] in_v = '0;
    logic [3:0][NT-1:0] out_d;
    logic [3:0][NT-1:0] out_v;
    logic [NS-1:0] conflict;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    logic [CW-1:0] m_cfg = '0;

    always #2.5 clk = ~clk;

    swbox_top #(.NTRK(NT), .NSW(NS)) i_swbox_top (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_data(cfg_data),
        .n_in(in_d[0]), .n_in_vld(in_v[0]), .s_in(in_d[1]), .s_in_vld(in_v[1]),
        .e_in(in_d[2]), .e_in_vld(in_v[2]), .w_in(in_d[3]), .w_in_vld(in_v[3]),
        .n_out(out_d[0]), .n_out_vld(out_v[0]), .s_out(out_d[1]), .s_out_vld(out_v[1]),
        .e_out(out_d[2]), .e_out_vld(out_v[2]), .w_out(out_d[3]), .w_out_vld(out_v[3]),
        .conflict(conflict)
    );

    // Side pair joined by link bit l (N=0,S=1,E=2,W=3).
    function automatic int end_a(int l);
        case (l)
            0: return 0; 1: return 2; 2: return 0;
            3: return 0; 4: return 1; default: return 1;
        endcase
    endfunction
    function automatic int end_b(int l);
        case (l)
            0: return 1; 1: return 3; 2: return 2;
            3: return 3; 4: return 2; default: return 3;
        endcase
    endfunction

    // Compare all outputs against the behavioural model; one check per call.
    task automatic compare(string tag);
        logic [3:0][NT-1:0] ed;
        logic [3:0][NT-1:0] ev;
        logic [NS-1:0] ec;
        ed = '0; ev = '0; ec = '0;
        for (int t = 0; t < NT; t++) begin
            if (t < NS) begin
                int lab [4];
                for (int i = 0; i < 4; i++) lab[i] = i;
                for (int p = 0; p < 4; p++) begin
                    for (int l = 0; l < 6; l++) begin
                        if (m_cfg[t*6 + l]) begin
                            int m;
                            m = (lab[end_a(l)] < lab[end_b(l)]) ? lab[end_a(l)] : lab[end_b(l)];
                            lab[end_a(l)] = m;
                            lab[end_b(l)] = m;
                        end
                    end
                end
                for (int s = 0; s < 4; s++) begin
                    for (int j = 0; j < 4; j++) begin
                        if (lab[j] == lab[s] && in_v[j][t]) begin
                            if (j != s) begin
                                ev[s][t] = 1'b1;
                                ed[s][t] = ed[s][t] | in_d[j][t];
                            end
                            for (int i = 0; i < 4; i++)
                                if (lab[i] == lab[s] && in_v[i][t] && in_d[i][t] != in_d[j][t])
                                    ec[t] = 1'b1;
                        end
                    end
                end
            end else begin
                ed[0][t] = in_d[1][t]; ev[0][t] = in_v[1][t];
                ed[1][t] = in_d[0][t]; ev[1][t] = in_v[0][t];
                ed[2][t] = in_d[3][t]; ev[2][t] = in_v[3][t];
                ed[3][t] = in_d[2][t]; ev[3][t] = in_v[2][t];
            end
        end
        n_checks++;
        if (out_d !== ed || out_v !== ev || conflict !== ec) begin
            n_fail++;
            $display("FAIL %s: got d=%h v=%h c=%b expected d=%h v=%h c=%b",
                     tag, out_d, out_v, conflict, ed, ev, ec);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, sample after it.
    task automatic step(string tag, logic ld, logic [CW-1:0] cfg,
                        logic [3:0][NT-1:0] d, logic [3:0][NT-1:0] v);
        @(negedge clk);
        cfg_load = ld; cfg_data = cfg; in_d = d; in_v = v;
        @(posedge clk);
        if (!rst_n) m_cfg = '0;
        else if (ld) m_cfg = cfg;
        #1;
        compare(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset clears configuration even when a load is requested.
        step("R1 during reset", 1'b1, '1, '1, '1);
        step("R1 during reset", 1'b0, '1, '1, '1);
        @(negedge clk); rst_n = 1'b1;
        step("R1 open after reset", 1'b0, '1, {4{4'b0101}}, '1);
        // R3: pass-through tracks 2 and 3 with all links closed.
        step("R3 load all links", 1'b1, '1, {4'b1000, 4'b0100, 4'b0010, 4'b0001}, '1);
        step("R3 pass-through", 1'b0, '1, {4'b0110, 4'b1001, 4'b0101, 4'b1010}, {4'b1100, 4'b0100, 4'b1000, 4'b0111});
        // R4: N-S link only (bit 0) on track 0; drive north 1.
        step("R4 north to south", 1'b1, 12'h001, {4'b0, 4'b0, 4'b0, 4'b0001}, {4'b0, 4'b0, 4'b0, 4'b0001});
        step("R4 south to north", 1'b0, 12'h001, {4'b0, 4'b0, 4'b0000, 4'b0}, {4'b0, 4'b0, 4'b0001, 4'b0});
        // R6: only the north end drives; north must not see itself.
        step("R6 no self echo", 1'b0, 12'h001, {4'b0, 4'b0, 4'b0, 4'b0001}, {4'b0, 4'b0, 4'b0, 4'b0001});
        // R5: N-E (bit 2) and S-E (bit 4) carry north to south.
        step("R5 chain N-E-S", 1'b1, 12'h014, {4'b0, 4'b0, 4'b0, 4'b0001}, {4'b0, 4'b0, 4'b0, 4'b0001});
        // R5: N-E, E-W, S-W chain of three links.
        step("R5 chain of three", 1'b1, 12'h026, {4'b0, 4'b0, 4'b0, 4'b0001}, {4'b0, 4'b0, 4'b0, 4'b0001});
        // R7: opposite drivers on one net, then agreeing drivers.
        step("R7 clash", 1'b1, 12'h001, {4'b0, 4'b0, 4'b0000, 4'b0001}, {4'b0, 4'b0, 4'b0001, 4'b0001});
        step("R7 agree", 1'b0, 12'h001, {4'b0, 4'b0, 4'b0001, 4'b0001}, {4'b0, 4'b0, 4'b0001, 4'b0001});
        step("R7 OR of drivers", 1'b1, 12'h014, {4'b0, 4'b0001, 4'b0, 4'b0}, {4'b0, 4'b0001, 4'b0001, 4'b0});
        // R8: only track 1 configured; track 0 stays silent.
        step("R8 track isolation", 1'b1, 12'hFC0, {4'b0011, 4'b0011, 4'b0011, 4'b0011}, {4'b0001, 4'b0001, 4'b0001, 4'b0001});
        // R2: cfg_data changes while load is low have no effect.
        step("R2 hold", 1'b0, 12'h03F, {4'b0, 4'b0, 4'b0, 4'b0001}, {4'b0, 4'b0, 4'b0, 4'b0001});
        step("R2 load takes effect", 1'b1, 12'h03F, {4'b0, 4'b0, 4'b0, 4'b0001}, {4'b0, 4'b0, 4'b0, 4'b0001});
        // R5 R7 R8: sweep every track-0 setting, track 1 complementary.
        for (int c = 0; c < 64; c++) begin
            logic [11:0] w;
            w = {~c[5:0], c[5:0]};
            step("R5 sweep load", 1'b1, w, {4{4'b0101}}, {4{4'b0011}});
            step("R5 sweep single", 1'b0, w, {4'b0, 4'b0, 4'b0, 4'b0011}, {4'b0, 4'b0, 4'b0, 4'b0011});
            step("R7 sweep mixed", 1'b0, w, {4'b0011, 4'b0000, 4'b0011, 4'b0000}, {4'b0011, 4'b0011, 4'b0000, 4'b0011});
            step("R8 sweep pair", 1'b0, w, {4'b0, 4'b0010, 4'b0, 4'b0001}, {4'b0, 4'b0010, 4'b0, 4'b0001});
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule